// File: doc/BRIEF.md
# Three-Wire Serial Command Decoder

This block is the serial front end of a display controller. A host drives a framing strobe (active low), a shift clock that idles high and a data line. Each byte travels least significant bit first and is sampled on the rising shift-clock edge. The first complete byte after the strobe falls is a command, and its top two bits select one of four classes. The bytes that follow it are write data or read slots, depending on the command in force.

The block holds the configuration the rest of the controller uses: the digit/segment mode, the display on/off state with its dimming step, the key-scan enable, the access-type register and the display-RAM address. Write data turns into one-cycle RAM write strobes, with an address that either advances or stays fixed, or it is written to an active-low LED port. In read modes the block puts key-matrix or switch bytes on a data-out pull-down enable, which changes on the falling shift-clock edge. All serial inputs are sampled by the system clock, so the shift clock must be much slower than the system clock.

Top module: `disp_serial_ctrl`

## Requirements
- R1: The first byte after `selN` falls is a command, assembled LSB first from `sdin` on rising `sclk`. Bits 7:6 select the class: 00 mode, 01 access setting, 10 display control, 11 address. `sclk` has no effect while `selN` is high.
- R2: If `selN` rises before the eighth bit of a byte, that byte is dropped with no register change and no RAM write, and the next frame decodes normally.
- R3: A display-control command sets `dispOn` from bit 3 and `dimLevel` from bits 2:0, and sets `scanEn` to 1.
- R4: A mode command stores bits 3:0 when bit 3 is 1, and 0000 (eight digits) when bit 3 is 0. If the stored value changes, `dispOn` and `scanEn` are cleared. A command equal to the current mode changes nothing.
- R5: An access-setting command stores bits 3:0. Bits 1:0 select 00 RAM write, 01 LED write, 10 key read, 11 switch read. Bit 2 = 1 selects a fixed address. Bit 3 drives `testMode`.
- R6: In RAM-write mode with increment, each data byte produces a single-cycle `ramWe` carrying the current address and the byte, and then the address advances by one.
- R7: With the fixed-address bit set, successive data bytes are all written to the same address.
- R8: An address command loads bits 5:0. While the address is 30h or above, data bytes produce no write. Auto-increment stops after 2Fh, so later bytes in the frame are dropped.
- R9: In LED-write mode, data bits 4:0 go to `ledN` (active low, bit 0 = first LED) and bits 7:5 are ignored.
- R10: In key-read mode, read byte n is `keyData[8n+7:8n]`. Bytes are sent LSB first, each bit presented on a falling `sclk` edge, and the sequence wraps to byte 0 after the last byte.
- R11: In switch-read mode, every read byte is `{4'b0000, swIn}`.
- R12: `doutLow` is 1 only during a read slot for a 0 bit. It is 0 for 1 bits and whenever `selN` is high.
- R13: After reset: mode 1111, display off, dim 000, scan off, access setting 0000, address 00h, `ledN` all ones, no write, `doutLow` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial shift clock, idles high |
| sdin | input | 1 | Serial data in |
| keyData | input | 8*KEY_BYTES | Key matrix snapshot, byte n read n-th |
| swIn | input | SW_W | Switch inputs |
| doutLow | output | 1 | Pull-down enable for serial data out |
| gridMode | output | 4 | Digit/segment mode |
| dispOn | output | 1 | Display enable |
| dimLevel | output | 3 | Dimming step |
| scanEn | output | 1 | Key scanning enable |
| testMode | output | 1 | Test mode flag |
| ledN | output | LED_W | LED port, active low |
| ramWe | output | 1 | Display RAM write strobe |
| ramAddr | output | ADDR_W | Display RAM write address |
| ramData | output | 8 | Display RAM write data |

## Verification
A bit counter that has slipped out of step shows up at once as a wrong byte on `ramData`, or as a stray `ramWe` at the end of the first frame that follows. A stale mode or access register shows up when a mode change fails to blank `dispOn`, or when a data byte is routed to the wrong target within a frame. The read shifter and the key-byte index are observed bit by bit on `doutLow`, so an off-by-one in either shows up within one read byte, or at the wrap after the sixth byte. A latched strobe state shows up as `doutLow` held after the frame ends.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_DSET = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_ADDR = 2'b11
  } cmdClass_t;

  typedef enum logic [1:0] {
    ACC_RAM = 2'b00,
    ACC_LED = 2'b01,
    ACC_KEY = 2'b10,
    ACC_SW  = 2'b11
  } access_t;

  typedef struct packed {
    logic shiftIn;
    logic cmdDone;
    logic dataDone;
    logic readStart;
    logic readFall;
  } ctrlStrobe_t;
endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        sclk,
  input  logic        sdin,
  input  logic [1:0]  rxClass,
  input  logic        rxReadBit,
  output ctrlStrobe_t stb,
  output logic        sdinBit,
  output logic        inRead
);
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_SKIP} state_t;

  state_t state;
  state_t cmdNext;
  logic selQ, sclkQ, sclkPrev, sdinQ;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic active, rise, fall, byteEnd;

  assign active  = !selQ;
  assign rise    = sclkQ && !sclkPrev;
  assign fall    = !sclkQ && sclkPrev;
  assign sdinBit = sdinQ;
  assign inRead  = (state == S_READ);

  always_comb begin
    case (cmdClass_t'(rxClass))
      CLS_DSET: cmdNext = rxReadBit ? S_READ : S_DATA;
      CLS_ADDR: cmdNext = S_DATA;
      default:  cmdNext = S_SKIP;
    endcase
  end

  always_comb begin
    stb.shiftIn   = active && rise && (state == S_CMD || state == S_DATA);
    byteEnd       = stb.shiftIn && (bitCnt == BIT_CNT_W'(BYTE_W - 1));
    stb.cmdDone   = byteEnd && (state == S_CMD);
    stb.dataDone  = byteEnd && (state == S_DATA);
    stb.readStart = stb.cmdDone && (cmdNext == S_READ);
    stb.readFall  = active && fall && (state == S_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ     <= 1'b1;
      sclkQ    <= 1'b1;
      sclkPrev <= 1'b1;
      sdinQ    <= 1'b0;
      state    <= S_IDLE;
      bitCnt   <= '0;
    end else begin
      selQ     <= selN;
      sclkQ    <= sclk;
      sclkPrev <= sclkQ;
      sdinQ    <= sdin;
      if (selQ) begin
        state  <= S_IDLE;
        bitCnt <= '0;
      end else if (state == S_IDLE) begin
        state  <= S_CMD;
        bitCnt <= '0;
      end else if (stb.shiftIn) begin
        bitCnt <= bitCnt + 1'b1;
        if (byteEnd) state <= (state == S_CMD) ? cmdNext : S_DATA;
      end
    end
  end
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int ADDR_LIMIT = 48,
  parameter int KEY_BYTES  = 6,
  parameter int LED_W      = 5,
  parameter int SW_W       = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             stb,
  input  logic                    sdinBit,
  input  logic [BYTE_W*KEY_BYTES-1:0] keyData,
  input  logic [SW_W-1:0]         swIn,
  output logic [BYTE_W-1:0]       rxNext,
  output logic [3:0]              gridMode,
  output logic                    dispOn,
  output logic [2:0]              dimLevel,
  output logic                    scanEn,
  output logic                    testMode,
  output logic [LED_W-1:0]        ledN,
  output logic                    ramWe,
  output logic [ADDR_W-1:0]       ramAddr,
  output logic [BYTE_W-1:0]       ramData,
  output logic                    outBit
);
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int KEY_IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

  logic [BYTE_W-1:0]    rxShift;
  logic [3:0]           dataSet;
  logic [ADDR_W-1:0]    addrReg;
  logic [BYTE_W-1:0]    outShift;
  logic [BIT_CNT_W-1:0] outCnt;
  logic [KEY_IDX_W-1:0] keyIdx;
  logic                 readSw;
  logic [3:0]           newMode;
  logic                 addrValid;
  logic [BYTE_W-1:0]    swByte;
  logic [BYTE_W-1:0]    keyByte;

  assign rxNext    = {sdinBit, rxShift[BYTE_W-1:1]};
  assign newMode   = rxNext[3] ? rxNext[3:0] : 4'b0000;
  assign addrValid = int'(addrReg) < ADDR_LIMIT;
  assign swByte    = {{(BYTE_W-SW_W){1'b0}}, swIn};
  assign keyByte   = keyData[int'(keyIdx)*BYTE_W +: BYTE_W];
  assign testMode  = dataSet[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      gridMode <= 4'b1111;
      dispOn   <= 1'b0;
      dimLevel <= '0;
      scanEn   <= 1'b0;
      dataSet  <= '0;
      addrReg  <= '0;
      ledN     <= '1;
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramData  <= '0;
    end else begin
      ramWe <= 1'b0;
      if (stb.shiftIn) rxShift <= rxNext;
      if (stb.cmdDone) begin
        case (cmdClass_t'(rxNext[7:6]))
          CLS_MODE: if (newMode != gridMode) begin
            gridMode <= newMode;
            dispOn   <= 1'b0;
            scanEn   <= 1'b0;
          end
          CLS_DSET: dataSet <= rxNext[3:0];
          CLS_CTRL: begin
            dimLevel <= rxNext[2:0];
            dispOn   <= rxNext[3];
            scanEn   <= 1'b1;
          end
          default:  addrReg <= rxNext[ADDR_W-1:0];
        endcase
      end
      if (stb.dataDone) begin
        case (access_t'(dataSet[1:0]))
          ACC_RAM: if (addrValid) begin
            ramWe   <= 1'b1;
            ramAddr <= addrReg;
            ramData <= rxNext;
            if (!dataSet[2]) addrReg <= addrReg + 1'b1;
          end
          ACC_LED: ledN <= rxNext[LED_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      outCnt   <= '0;
      keyIdx   <= '0;
      readSw   <= 1'b0;
      outBit   <= 1'b1;
    end else if (stb.readStart) begin
      readSw   <= rxNext[0];
      outShift <= rxNext[0] ? swByte : keyData[BYTE_W-1:0];
      keyIdx   <= KEY_IDX_W'(1 % KEY_BYTES);
      outCnt   <= '0;
      outBit   <= 1'b1;
    end else if (stb.readFall) begin
      outBit <= outShift[0];
      outCnt <= outCnt + 1'b1;
      if (outCnt == BIT_CNT_W'(BYTE_W - 1)) begin
        outShift <= readSw ? swByte : keyByte;
        keyIdx   <= (int'(keyIdx) == KEY_BYTES - 1) ? '0 : keyIdx + 1'b1;
      end else begin
        outShift <= outShift >> 1;
      end
    end
  end
endmodule

// File: rtl/disp_serial_ctrl.sv
module disp_serial_ctrl
  import dsc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int ADDR_LIMIT = 48,
  parameter int KEY_BYTES  = 6,
  parameter int LED_W      = 5,
  parameter int SW_W       = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        selN,
  input  logic                        sclk,
  input  logic                        sdin,
  input  logic [BYTE_W*KEY_BYTES-1:0] keyData,
  input  logic [SW_W-1:0]             swIn,
  output logic                        doutLow,
  output logic [3:0]                  gridMode,
  output logic                        dispOn,
  output logic [2:0]                  dimLevel,
  output logic                        scanEn,
  output logic                        testMode,
  output logic [LED_W-1:0]            ledN,
  output logic                        ramWe,
  output logic [ADDR_W-1:0]           ramAddr,
  output logic [BYTE_W-1:0]           ramData
);
  ctrlStrobe_t       stb;
  logic              sdinBit;
  logic              inRead;
  logic              outBit;
  logic [BYTE_W-1:0] rxNext;

  dsc_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .selN      (selN),
    .sclk      (sclk),
    .sdin      (sdin),
    .rxClass   (rxNext[7:6]),
    .rxReadBit (rxNext[1]),
    .stb       (stb),
    .sdinBit   (sdinBit),
    .inRead    (inRead)
  );

  dsc_datapath #(
    .ADDR_W     (ADDR_W),
    .ADDR_LIMIT (ADDR_LIMIT),
    .KEY_BYTES  (KEY_BYTES),
    .LED_W      (LED_W),
    .SW_W       (SW_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sdinBit  (sdinBit),
    .keyData  (keyData),
    .swIn     (swIn),
    .rxNext   (rxNext),
    .gridMode (gridMode),
    .dispOn   (dispOn),
    .dimLevel (dimLevel),
    .scanEn   (scanEn),
    .testMode (testMode),
    .ledN     (ledN),
    .ramWe    (ramWe),
    .ramAddr  (ramAddr),
    .ramData  (ramData),
    .outBit   (outBit)
  );

  assign doutLow = inRead && !outBit;
endmodule

// File: rtl/disp_serial_ctrl_chk.sv
module disp_serial_ctrl_chk #(
  parameter int ADDR_W     = 6,
  parameter int ADDR_LIMIT = 48,
  parameter int LED_W      = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              doutLow,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [LED_W-1:0]  ledN,
  input logic [3:0]        gridMode,
  input logic              dispOn,
  input logic              scanEn
);
  a_r12_release_idle: assert property (@(posedge clk) disable iff (!rstN)
    (selN && $past(selN) && $past(selN, 2)) |-> !doutLow);

  a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (int'(ramAddr) < ADDR_LIMIT));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe);

  a_r9_led_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(selN, 2) |-> $stable(ledN));

  a_r1_mode_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(selN, 2) |-> $stable(gridMode));

  a_r4_change_blanks: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gridMode) |-> (!dispOn && !scanEn));
endmodule

bind disp_serial_ctrl disp_serial_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .ADDR_LIMIT (ADDR_LIMIT),
  .LED_W      (LED_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .selN     (selN),
  .doutLow  (doutLow),
  .ramWe    (ramWe),
  .ramAddr  (ramAddr),
  .ledN     (ledN),
  .gridMode (gridMode),
  .dispOn   (dispOn),
  .scanEn   (scanEn)
);

// File: tb/disp_serial_ctrl_test.sv
`timescale 1ns/1ps
module disp_serial_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic sclk = 1'b1;
  logic sdin = 1'b0;
  logic [47:0] keyData = 48'hA53C0FF09669;
  logic [3:0]  swIn = 4'b1010;
  logic doutLow, dispOn, scanEn, testMode, ramWe;
  logic [3:0] gridMode;
  logic [2:0] dimLevel;
  logic [4:0] ledN;
  logic [5:0] ramAddr;
  logic [7:0] ramData;

  int total = 0;
  int bad = 0;
  int wrN = 0;
  logic [5:0] wrA [64];
  logic [7:0] wrD [64];

  always #2.5 clk = ~clk;

  disp_serial_ctrl uut (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdin(sdin),
    .keyData(keyData), .swIn(swIn), .doutLow(doutLow), .gridMode(gridMode),
    .dispOn(dispOn), .dimLevel(dimLevel), .scanEn(scanEn), .testMode(testMode),
    .ledN(ledN), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData)
  );

  always @(negedge clk) begin
    if (ramWe && wrN < 64) begin
      wrA[wrN] = ramAddr;
      wrD[wrN] = ramData;
      wrN = wrN + 1;
    end
  end

  // cmd, mode, on, dim, scan
  localparam logic [16:0] VEC [8] = '{
    {8'h8F, 4'hF, 1'b1, 3'd7, 1'b1},
    {8'h0F, 4'hF, 1'b1, 3'd7, 1'b1},
    {8'h0C, 4'hC, 1'b0, 3'd7, 1'b0},
    {8'h8A, 4'hC, 1'b1, 3'd2, 1'b1},
    {8'h05, 4'h0, 1'b0, 3'd2, 1'b0},
    {8'h82, 4'h0, 1'b0, 3'd2, 1'b1},
    {8'h03, 4'h0, 1'b0, 3'd2, 1'b1},
    {8'h3F, 4'hF, 1'b0, 3'd2, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frameStart();
    @(negedge clk) selN = 1'b0;
    waitClk(4);
  endtask

  task automatic frameEnd();
    waitClk(2);
    selN = 1'b1;
    waitClk(8);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      sdin = b[i];
      waitClk(4);
      sclk = 1'b1;
      waitClk(4);
    end
  endtask

  task automatic readByte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      waitClk(4);
      v[i] = ~doutLow;
      sclk = 1'b1;
      waitClk(4);
    end
  endtask

  task automatic oneByteFrame(input logic [7:0] b);
    frameStart();
    sendBits(b, 8);
    frameEnd();
  endtask

  initial begin
    #750000;
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] rd;
    logic [7:0] expKey [7];
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);

    // R13 reset state
    check(gridMode == 4'hF && !dispOn && dimLevel == 3'd0 && !scanEn, "R13 reset cfg",
          {gridMode, dispOn, dimLevel, scanEn}, {4'hF, 1'b0, 3'd0, 1'b0});
    check(ledN == 5'h1F && !testMode && !doutLow && !ramWe, "R13 reset outputs",
          {ledN, testMode, doutLow, ramWe}, {5'h1F, 3'b000});

    // R1 R3 R4 vector table
    for (int k = 0; k < 8; k++) begin
      oneByteFrame(VEC[k][16:9]);
      check({gridMode, dispOn, dimLevel, scanEn} == VEC[k][8:0], "R3/R4 vector",
            {gridMode, dispOn, dimLevel, scanEn}, VEC[k][8:0]);
    end

    // R5 test mode bit
    oneByteFrame(8'h48);
    check(testMode == 1'b1, "R5 test bit set", testMode, 1);
    oneByteFrame(8'h40);
    check(testMode == 1'b0, "R5 test bit clear", testMode, 0);

    // R9 LED port, upper bits ignored
    frameStart(); sendBits(8'h41, 8); sendBits(8'hEA, 8); frameEnd();
    check(ledN == 5'b01010, "R9 led write", ledN, 5'b01010);

    // R6 R8 increment and stop past 2Fh
    oneByteFrame(8'h40);
    base = wrN;
    frameStart(); sendBits(8'hEE, 8); sendBits(8'hAA, 8); sendBits(8'hBB, 8); sendBits(8'hCC, 8); frameEnd();
    check(wrN - base == 2, "R8 stop after 2F count", wrN - base, 2);
    check(wrA[base] == 6'h2E && wrD[base] == 8'hAA, "R6 first write", {wrA[base], wrD[base]}, {6'h2E, 8'hAA});
    check(wrA[base+1] == 6'h2F && wrD[base+1] == 8'hBB, "R6 incremented write",
          {wrA[base+1], wrD[base+1]}, {6'h2F, 8'hBB});

    // R7 fixed address
    oneByteFrame(8'h44);
    base = wrN;
    frameStart(); sendBits(8'hC5, 8); sendBits(8'h11, 8); sendBits(8'h22, 8); frameEnd();
    check(wrN - base == 2 && wrA[base] == 6'h05 && wrA[base+1] == 6'h05 && wrD[base+1] == 8'h22,
          "R7 fixed address", {wrA[base], wrA[base+1], wrD[base+1]}, {6'h05, 6'h05, 8'h22});

    // R8 invalid address
    oneByteFrame(8'h40);
    base = wrN;
    frameStart(); sendBits(8'hF0, 8); sendBits(8'h55, 8); frameEnd();
    check(wrN == base, "R8 invalid address dropped", wrN - base, 0);
    frameStart(); sendBits(8'hC1, 8); sendBits(8'h66, 8); frameEnd();
    check(wrN - base == 1 && wrA[base] == 6'h01 && wrD[base] == 8'h66, "R8 valid reload",
          {wrA[base], wrD[base]}, {6'h01, 8'h66});

    // R2 abort mid byte
    base = wrN;
    frameStart(); sendBits(8'hC3, 8); sendBits(8'h77, 5); frameEnd();
    check(wrN == base, "R2 partial data dropped", wrN - base, 0);
    frameStart(); sendBits(8'h0C, 5); frameEnd();
    check(gridMode == 4'hF, "R2 partial command dropped", gridMode, 4'hF);
    frameStart(); sendBits(8'hC3, 8); sendBits(8'h77, 8); frameEnd();
    check(wrN - base == 1 && wrA[base] == 6'h03 && wrD[base] == 8'h77, "R2 recovery frame",
          {wrA[base], wrD[base]}, {6'h03, 8'h77});

    // R11 switch read
    frameStart(); sendBits(8'h43, 8);
    for (int j = 0; j < 2; j++) begin
      readByte(rd);
      check(rd == 8'h0A, "R11 switch byte", rd, 8'h0A);
    end
    frameEnd();

    // R10 key read with wrap
    expKey = '{8'h69, 8'h96, 8'hF0, 8'h0F, 8'h3C, 8'hA5, 8'h69};
    frameStart(); sendBits(8'h42, 8);
    for (int j = 0; j < 7; j++) begin
      readByte(rd);
      check(rd == expKey[j], "R10 key byte", rd, expKey[j]);
    end
    // R12 released once the frame ends
    frameEnd();
    check(!doutLow, "R12 released after frame", doutLow, 0);

    // R12 no pull-down while strobe high and clock toggles
    sendBits(8'h00, 8);
    check(!doutLow && gridMode == 4'hF && wrN == base + 1, "R1 R12 clock ignored when idle",
          {doutLow, gridMode}, {1'b0, 4'hF});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule